// File: doc/BRIEF.md
# Debug Authentication Session Controller

This block keeps the authentication state of one debug session that several transport ports can reach. It takes events from an authentication engine: a capability choice, a pass or fail verdict with a granted rights value, a detach notice and a close request. From these it drives an authenticated flag, a per-transport enable vector, a 32-bit read-only access-rights word, a key-destroy pulse and an error pulse. The cryptography lives elsewhere. This block only sequences the session and enforces its rules.

After a transport authenticates, that transport owns the session and every other transport is locked out. An inactivity timer runs while the session is open, and only transactions from the owner reload it. When the timer runs out the session drops, an error is reported and the rights fall back to a default set. Debug feature requests are granted only where the active rights word has the matching bit set.

Rights bit meanings, by position: bit 0 global reset, bit 1 direct system bus access, bit 2 M-mode debugging, bit 3 global hart access, bit 4 lock out other transports on authentication, bit 5 forbid tampering with debug CSR writes, bit 6 expose debug state to M-mode. Bits 7 to 31 are reserved.

Top module: `dbg_auth_session`

## Requirements
- R1: After reset the block is not authenticated, all transports are enabled, `rights` equals DEFAULT_RIGHTS, and `key_destroy`, `err` and `port_err` are zero.
- R2: In the idle state, `cap_valid` with a nonzero `cap_id` starts negotiation, and the owner is `auth_port`. A later `auth_pass` sets `authenticated` on the next clock, and `rights` then carries `auth_rights[6:0]`.
- R3: In the idle state, `cap_valid` with `cap_id` equal to 0 means no capability was chosen. The session closes, every transport is disabled, and it stays so until `detach` or `close_req`.
- R4: `auth_fail` during negotiation returns the block to idle and gives a one-cycle `err` pulse.
- R5: While authenticated, `port_en` is one-hot on the owning transport.
- R6: If TIMEOUT_CYC consecutive authenticated cycles pass with no owner transaction, `authenticated` clears on the next clock, `err` pulses for one cycle, and `rights` returns to DEFAULT_RIGHTS.
- R7: An owner `port_req` reloads the inactivity timer. Requests from other transports do not reload it.
- R8: `detach` or `close_req` in any state other than idle gives a one-cycle `key_destroy` pulse and returns the block to idle. Detach and close take priority over a timeout in the same cycle.
- R9: `rights[31:7]` always read as zero. While not authenticated, `rights` equals DEFAULT_RIGHTS.
- R10: `feat_gnt` equals `feat_req` ANDed with `rights[6:0]`.
- R11: A `port_req` on a transport whose `port_en` bit is low sets the matching `port_err` bit on the next clock, for one cycle.
- R12: `auth_pass`, `auth_fail` and `cap_valid` have no effect in states where they do not apply (for example, `auth_pass` while idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_req | input | NUM_PORTS | One transaction strobe per transport |
| cap_valid | input | 1 | Capability selection event |
| cap_id | input | 16 | Selected capability identifier, 0 means none |
| auth_port | input | $clog2(NUM_PORTS) | Transport that is negotiating |
| auth_pass | input | 1 | Authentication succeeded |
| auth_fail | input | 1 | Authentication failed |
| auth_rights | input | 32 | Rights granted on success |
| detach | input | 1 | Debugger detached |
| close_req | input | 1 | Debugger closes the session |
| feat_req | input | 7 | Debug feature requests |
| authenticated | output | 1 | Session authenticated flag |
| port_en | output | NUM_PORTS | Per-transport access enable |
| rights | output | 32 | Active access-rights word |
| feat_gnt | output | 7 | Granted debug features |
| key_destroy | output | 1 | One-cycle session key destroy pulse |
| err | output | 1 | One-cycle error pulse (fail or timeout) |
| port_err | output | NUM_PORTS | One-cycle refusal pulse per blocked transport |

## Verification
The bench builds the block with three transports, so there is always a third transport that is neither the owner nor the negotiating port. It uses TIMEOUT_CYC of 12, short enough to run the timer to expiry several times and to reload it just before expiry. DEFAULT_RIGHTS is 7'h48, which differs from every granted set the bench uses, so falling back to the default after timeout or detach shows at the `rights` and `feat_gnt` ports.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;
    localparam int FEAT_W   = 7;
    localparam int RIGHTS_W = 32;
    localparam int CAP_W    = 16;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_NEGO   = 2'd1,
        S_AUTH   = 2'd2,
        S_CLOSED = 2'd3
    } sess_state_e;
endpackage

// File: rtl/dbg_auth_timer.sv
module dbg_auth_timer #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        expired = 1'b0;
        if (load) begin
            cnt_d = RELOAD;
        end else if (run) begin
            if (cnt_q == CW'(1)) begin
                expired = 1'b1;
            end else begin
                cnt_d = cnt_q - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dbg_auth_port_gate.sv
module dbg_auth_port_gate
    import dbg_auth_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  sess_state_e          state,
    input  logic [PW-1:0]        owner,
    input  logic [NUM_PORTS-1:0] port_req,
    output logic [NUM_PORTS-1:0] port_en,
    output logic [NUM_PORTS-1:0] port_err,
    output logic                 owner_req
);
    logic [NUM_PORTS-1:0] err_d, err_q;
    logic [NUM_PORTS-1:0] own_hit;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        always_comb begin
            own_hit[i] = (owner == PW'(i));
            unique case (state)
                S_IDLE, S_NEGO: port_en[i] = 1'b1;
                S_AUTH:         port_en[i] = own_hit[i];
                default:        port_en[i] = 1'b0;
            endcase
            err_d[i] = port_req[i] & ~port_en[i];
        end
    end

    assign owner_req = (state == S_AUTH) && |(port_req & own_hit);
    assign port_err  = err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end
endmodule

// File: rtl/dbg_auth_session.sv
module dbg_auth_session
    import dbg_auth_pkg::*;
#(
    parameter int               NUM_PORTS      = 3,
    parameter int               TIMEOUT_CYC    = 1000,
    parameter logic [FEAT_W-1:0] DEFAULT_RIGHTS = 7'h08,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] port_req,
    input  logic                 cap_valid,
    input  logic [CAP_W-1:0]     cap_id,
    input  logic [PW-1:0]        auth_port,
    input  logic                 auth_pass,
    input  logic                 auth_fail,
    input  logic [RIGHTS_W-1:0]  auth_rights,
    input  logic                 detach,
    input  logic                 close_req,
    input  logic [FEAT_W-1:0]    feat_req,
    output logic                 authenticated,
    output logic [NUM_PORTS-1:0] port_en,
    output logic [RIGHTS_W-1:0]  rights,
    output logic [FEAT_W-1:0]    feat_gnt,
    output logic                 key_destroy,
    output logic                 err,
    output logic [NUM_PORTS-1:0] port_err
);
    typedef struct packed {
        sess_state_e       state;
        logic [PW-1:0]     owner;
        logic [FEAT_W-1:0] granted;
        logic              err;
        logic              kd;
    } sess_t;

    sess_t s_d, s_q;
    logic  owner_req, expired, tmr_load, end_req;
    logic [FEAT_W-1:0] active;

    assign end_req  = detach | close_req;
    assign tmr_load = ((s_q.state == S_NEGO) && auth_pass && !end_req) || owner_req;

    dbg_auth_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (s_q.state == S_AUTH),
        .expired (expired)
    );

    dbg_auth_port_gate #(.NUM_PORTS(NUM_PORTS)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (s_q.state),
        .owner     (s_q.owner),
        .port_req  (port_req),
        .port_en   (port_en),
        .port_err  (port_err),
        .owner_req (owner_req)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        s_d.kd  = 1'b0;
        unique case (s_q.state)
            S_IDLE: begin
                if (cap_valid) begin
                    s_d.owner = auth_port;
                    s_d.state = (cap_id == '0) ? S_CLOSED : S_NEGO;
                end
            end
            S_NEGO: begin
                if (end_req) begin
                    s_d.state = S_IDLE;
                    s_d.kd    = 1'b1;
                end else if (auth_pass) begin
                    s_d.state   = S_AUTH;
                    s_d.granted = auth_rights[FEAT_W-1:0];
                end else if (auth_fail) begin
                    s_d.state = S_IDLE;
                    s_d.err   = 1'b1;
                end
            end
            S_AUTH: begin
                if (end_req) begin
                    s_d.state   = S_IDLE;
                    s_d.kd      = 1'b1;
                    s_d.granted = '0;
                end else if (expired) begin
                    s_d.state   = S_IDLE;
                    s_d.err     = 1'b1;
                    s_d.granted = '0;
                end
            end
            default: begin
                if (end_req) begin
                    s_d.state = S_IDLE;
                    s_d.kd    = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: S_IDLE, owner: '0, granted: '0, err: 1'b0, kd: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign authenticated = (s_q.state == S_AUTH);
    assign active        = authenticated ? s_q.granted : DEFAULT_RIGHTS;
    assign rights        = {{(RIGHTS_W-FEAT_W){1'b0}}, active};
    assign feat_gnt      = feat_req & active;
    assign key_destroy   = s_q.kd;
    assign err           = s_q.err;
endmodule

// File: rtl/dbg_auth_session_chk.sv
module dbg_auth_session_chk #(
    parameter int         NUM_PORTS      = 3,
    parameter logic [6:0] DEFAULT_RIGHTS = 7'h08
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] port_req,
    input logic                 detach,
    input logic                 close_req,
    input logic                 authenticated,
    input logic [NUM_PORTS-1:0] port_en,
    input logic [31:0]          rights,
    input logic                 key_destroy,
    input logic [NUM_PORTS-1:0] port_err
);
    a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        authenticated |-> $countones(port_en) == 1);

    a_r8_end_destroys_key: assert property (@(posedge clk) disable iff (!rst_n)
        (authenticated && (detach || close_req)) |=> (key_destroy && !authenticated));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rights[31:7] == '0);

    a_r9_default_rights: assert property (@(posedge clk) disable iff (!rst_n)
        !authenticated |-> rights[6:0] == DEFAULT_RIGHTS);

    a_r11_blocked_refused: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_req & ~port_en) != '0) |=> (port_err != '0));

    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        key_destroy |=> !key_destroy);
endmodule

bind dbg_auth_session dbg_auth_session_chk #(
    .NUM_PORTS      (NUM_PORTS),
    .DEFAULT_RIGHTS (DEFAULT_RIGHTS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_req      (port_req),
    .detach        (detach),
    .close_req     (close_req),
    .authenticated (authenticated),
    .port_en       (port_en),
    .rights        (rights),
    .key_destroy   (key_destroy),
    .port_err      (port_err)
);

// File: tb/test_dbg_auth_session.sv
module test_dbg_auth_session;
    localparam int         NP   = 3;
    localparam int         TO   = 12;
    localparam logic [6:0] DEF  = 7'h48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] port_req = '0;
    logic cap_valid = 1'b0;
    logic [15:0] cap_id = '0;
    logic [1:0] auth_port = '0;
    logic auth_pass = 1'b0, auth_fail = 1'b0;
    logic [31:0] auth_rights = '0;
    logic detach = 1'b0, close_req = 1'b0;
    logic [6:0] feat_req = '0;
    logic authenticated, key_destroy, err;
    logic [NP-1:0] port_en, port_err;
    logic [31:0] rights;
    logic [6:0] feat_gnt;

    int tests = 0, fails = 0, cycles = 0;

    always #10 clk = ~clk;

    dbg_auth_session #(.NUM_PORTS(NP), .TIMEOUT_CYC(TO), .DEFAULT_RIGHTS(DEF)) i_dbg_auth_session (
        .clk(clk), .rst_n(rst_n), .port_req(port_req), .cap_valid(cap_valid),
        .cap_id(cap_id), .auth_port(auth_port), .auth_pass(auth_pass),
        .auth_fail(auth_fail), .auth_rights(auth_rights), .detach(detach),
        .close_req(close_req), .feat_req(feat_req), .authenticated(authenticated),
        .port_en(port_en), .rights(rights), .feat_gnt(feat_gnt),
        .key_destroy(key_destroy), .err(err), .port_err(port_err));

    // reference model: 0 idle, 1 negotiating, 2 authenticated, 3 closed
    int m_st = 0, m_own = 0, m_cnt = TO;
    logic [6:0] m_gr = '0;
    bit m_err = 0, m_kd = 0;
    logic [NP-1:0] m_perr = '0;

    function automatic logic [NP-1:0] exp_en();
        logic [NP-1:0] e;
        for (int i = 0; i < NP; i++)
            e[i] = (m_st == 0 || m_st == 1) || (m_st == 2 && m_own == i);
        return e;
    endfunction

    function automatic logic [6:0] exp_act();
        return (m_st == 2) ? m_gr : DEF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_own = 0; m_cnt = TO; m_gr = '0; m_err = 0; m_kd = 0; m_perr = '0;
        end else begin
            int ns;
            bit ends, oreq;
            ns = m_st;
            ends = detach || close_req;
            m_perr = port_req & ~exp_en();
            m_err = 0; m_kd = 0;
            oreq = (m_st == 2) && port_req[m_own];
            case (m_st)
                0: if (cap_valid) begin m_own = auth_port; ns = (cap_id == 0) ? 3 : 1; end
                1: if (ends) begin ns = 0; m_kd = 1; end
                   else if (auth_pass) begin ns = 2; m_gr = auth_rights[6:0]; m_cnt = TO; end
                   else if (auth_fail) begin ns = 0; m_err = 1; end
                2: if (ends) begin ns = 0; m_kd = 1; end
                   else if (oreq) m_cnt = TO;
                   else if (m_cnt == 1) begin ns = 0; m_err = 1; end
                   else m_cnt--;
                default: if (ends) begin ns = 0; m_kd = 1; end
            endcase
            m_st = ns;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", what, act, exp, cycles);
        end
    endtask

    task automatic check_all();
        chk("R2/authenticated", 32'(authenticated), 32'(m_st == 2));
        chk("R5/port_en", 32'(port_en), 32'(exp_en()));
        chk("R9/rights", rights, {25'b0, exp_act()});
        chk("R10/feat_gnt", 32'(feat_gnt), 32'(feat_req & exp_act()));
        chk("R8/key_destroy", 32'(key_destroy), 32'(m_kd));
        chk("R6/err", 32'(err), 32'(m_err));
        chk("R11/port_err", 32'(port_err), 32'(m_perr));
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
        port_req = '0; cap_valid = 0; auth_pass = 0; auth_fail = 0;
        detach = 0; close_req = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic select(int p, logic [15:0] id);
        step(); cap_valid = 1; cap_id = id; auth_port = 2'(p);
    endtask

    task automatic pass(logic [31:0] r);
        step(); auth_pass = 1; auth_rights = r;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        feat_req = 7'h7f;
        repeat (2) @(negedge clk);
        check_all();                           // R1 reset values
        chk("R1/reset_en", 32'(port_en), 32'h7);
        rst_n = 1;
        idle(2);
        // R12: pass and fail while idle do nothing
        step(); auth_pass = 1; auth_rights = 32'h7f;
        step(); auth_fail = 1;
        idle(2);
        chk("R12/still_idle", 32'(authenticated), 32'h0);
        // R2: session on port 1, upper rights bits dropped
        select(1, 16'h007f);
        pass(32'hffff_ff35);
        step(); feat_req = 7'h0f;
        chk("R2/auth_set", 32'(authenticated), 32'h1);
        // R5, R11: ports 0 and 2 blocked and refused; R7 they do not keep alive
        for (int i = 0; i < 20; i++) begin
            step(); port_req = 3'b101 | ((i % 4 == 0) ? 3'b010 : 3'b000);
        end
        chk("R7/kept_alive", 32'(authenticated), 32'h1);
        // R6: blocked traffic only, run to timeout
        for (int i = 0; i < TO + 2; i++) begin step(); port_req = 3'b100; end
        chk("R6/timed_out", 32'(authenticated), 32'h0);
        // R7: reload just before expiry
        select(0, 16'h0003);
        pass(32'h0000_0051);
        idle(TO - 1);
        step(); port_req = 3'b001;
        idle(TO - 2);
        chk("R7/reload", 32'(authenticated), 32'h1);
        idle(4);
        // R4: fail during negotiation
        select(2, 16'h0001);
        step(); auth_fail = 1;
        idle(2);
        // R8: close during negotiation, detach while authenticated
        select(2, 16'h0002);
        step(); close_req = 1;
        idle(1);
        select(2, 16'h0002);
        pass(32'h0000_007f);
        idle(3);
        step(); detach = 1; port_req = 3'b011;
        idle(2);
        chk("R8/detached", 32'(authenticated), 32'h0);
        // R3: no capability selected closes the session
        select(1, 16'h0000);
        for (int i = 0; i < 4; i++) begin step(); port_req = 3'(i + 1); end
        step(); auth_pass = 1;                 // R12 ignored when closed
        step(); cap_valid = 1; cap_id = 16'h5;  // R12 ignored when closed
        idle(2);
        chk("R3/closed_en", 32'(port_en), 32'h0);
        step(); detach = 1;
        idle(2);
        chk("R3/reopened", 32'(port_en), 32'h7);
        // R8 priority: close and expiry in the same cycle
        select(1, 16'h0010);
        pass(32'h0000_0001);
        idle(TO - 1);
        step(); close_req = 1;
        idle(3);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule